// File: doc/BRIEF.md
# Integer Logical Execution Unit

This block is the logical-operations lane of a 32-bit load/store integer core. Once an operation has been decoded, the lane receives an operation code, two register operands, a 16-bit immediate, a record request and the current summary-overflow bit. One clock later it returns the 32-bit result. With the result it returns a four-bit condition field and a strobe that says whether that field should be written back as condition field 0.

The lane covers three kinds of operation:
- eight register-register bitwise operations, including the forms that complement an operand or the output;
- six immediate operations built from AND, OR and XOR, each in a low-half and a high-half placement;
- sign extension from a byte or from a halfword.

The record request decides the condition write for register and sign-extension operations. For the immediate group the opcode alone decides it.

Top module: `lgx_unit`

## Requirements
- R1: `op_i` is a 4-bit code. Codes 0, 1 and 2 return `a & b`, `a | b` and `a ^ b`.
- R2: Codes 3 to 7 return, in this order, `~(a & b)`, `~(a | b)`, `~(a ^ b)`, `a & ~b` and `a | ~b`.
- R3: Codes 8 and 9 are AND-immediate, 10 and 11 are OR-immediate, and 12 and 13 are XOR-immediate. The even code uses the immediate zero-extended into bits 15..0. The odd code places it in bits 31..16 with zeros below. The immediate is never sign-extended.
- R4: Code 14 returns operand A bits 7..0 sign-extended to 32 bits. Code 15 does the same for bits 15..0.
- R5: `cond_o` is {LT, GT, EQ, SO} in bits 3..0.
  - LT is result bit 31.
  - GT is set when the result is nonzero and bit 31 is clear.
  - EQ is set when the result is zero.
  - SO copies `so_i` from the accepted operation.
  - Exactly one of LT, GT and EQ is set.
- R6: For codes 0 to 7, 14 and 15, `cond_we_o` equals the accepted `rec_i`.
- R7: For codes 8 and 9, `cond_we_o` is 1 whatever `rec_i` is.
- R8: For codes 10 to 13, `cond_we_o` is 0 whatever `rec_i` is.
- R9: Outputs appear on the clock edge after the one on which `valid_i` is high. `valid_o` is high only in that cycle. `cond_we_o` is low whenever `valid_o` is low. The result holds its value during idle cycles.
- R10: While `rst` is high, `valid_o`, `result_o`, `cond_o` and `cond_we_o` are zero.
- R11: Code 1 with equal operands returns a copy of the operand (move register). With `rec_i` set, it also writes the condition field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| rec_i | input | 1 | Record request |
| a_i | input | 32 | Register operand A |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Unsigned immediate |
| so_i | input | 1 | Summary-overflow bit |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result |
| cond_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cond_we_o | output | 1 | Condition field write enable |

## Verification
Every opcode is swept with the record flag both clear and set. The operands are crossed over zero, all-ones, 0x80000000, 0x00008000, 0x7FFFFFFF and a mixed pattern, which together produce each of the LT, GT and EQ conditions. The immediates 0x8000 and 0xFFFF show whether the lane zero-extends or sign-extends, and whether the low or high placement was used. Byte and halfword values with the top bit set tell the two sign-extension widths apart. Random operands follow, with the summary-overflow bit toggling, to catch any swapped or inverted opcode decode.

// File: rtl/lgx_pkg.sv
package lgx_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_NAND  = 4'd3,
    OP_NOR   = 4'd4,
    OP_EQV   = 4'd5,
    OP_ANDC  = 4'd6,
    OP_ORC   = 4'd7,
    OP_ANDIL = 4'd8,
    OP_ANDIH = 4'd9,
    OP_ORIL  = 4'd10,
    OP_ORIH  = 4'd11,
    OP_XORIL = 4'd12,
    OP_XORIH = 4'd13,
    OP_SEXTB = 4'd14,
    OP_SEXTH = 4'd15
  } lgx_op_e;

  typedef enum logic [1:0] {
    K_AND = 2'd0,
    K_OR  = 2'd1,
    K_XOR = 2'd2
  } lgx_kind_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } lgx_crf_t;
endpackage

// File: rtl/lgx_bitwise.sv
module lgx_bitwise #(
  parameter int W = 32
) (
  input  logic [2:0]   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  import lgx_pkg::*;

  lgx_kind_e kind;
  logic      inv_b;
  logic      inv_y;
  logic [W-1:0] b_eff;
  logic [W-1:0] core;

  always_comb begin
    kind  = K_AND;
    inv_b = 1'b0;
    inv_y = 1'b0;
    unique case (sel_i)
      3'd0: kind = K_AND;
      3'd1: kind = K_OR;
      3'd2: kind = K_XOR;
      3'd3: begin kind = K_AND; inv_y = 1'b1; end
      3'd4: begin kind = K_OR;  inv_y = 1'b1; end
      3'd5: begin kind = K_XOR; inv_y = 1'b1; end
      3'd6: begin kind = K_AND; inv_b = 1'b1; end
      3'd7: begin kind = K_OR;  inv_b = 1'b1; end
      default: kind = K_AND;
    endcase
  end

  assign b_eff = inv_b ? ~b_i : b_i;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic r;
      always_comb begin
        unique case (kind)
          K_AND:   r = a_i[i] & b_eff[i];
          K_OR:    r = a_i[i] | b_eff[i];
          K_XOR:   r = a_i[i] ^ b_eff[i];
          default: r = 1'b0;
        endcase
      end
      assign core[i] = r ^ inv_y;
    end
  endgenerate

  assign y_o = core;
endmodule

// File: rtl/lgx_immed.sv
module lgx_immed #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [2:0]    sel_i,
  input  logic [W-1:0]  a_i,
  input  logic [IW-1:0] imm_i,
  output logic [W-1:0]  y_o
);
  import lgx_pkg::*;

  logic [W-1:0] imm_lo;
  logic [W-1:0] imm_hi;
  logic [W-1:0] opnd;
  lgx_kind_e    kind;

  assign imm_lo = W'(imm_i);
  assign imm_hi = imm_lo << IW;
  assign opnd   = sel_i[0] ? imm_hi : imm_lo;

  always_comb begin
    unique case (sel_i[2:1])
      2'd0:    kind = K_AND;
      2'd1:    kind = K_OR;
      2'd2:    kind = K_XOR;
      default: kind = K_AND;
    endcase
  end

  always_comb begin
    unique case (kind)
      K_AND:   y_o = a_i & opnd;
      K_OR:    y_o = a_i | opnd;
      K_XOR:   y_o = a_i ^ opnd;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/lgx_sext.sv
module lgx_sext #(
  parameter int W  = 32,
  parameter int BW = 8,
  parameter int HW = 16
) (
  input  logic         half_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] ext_b;
  logic [W-1:0] ext_h;

  assign ext_b = {{(W-BW){a_i[BW-1]}}, a_i[BW-1:0]};
  assign ext_h = {{(W-HW){a_i[HW-1]}}, a_i[HW-1:0]};
  assign y_o   = half_i ? ext_h : ext_b;
endmodule

// File: rtl/lgx_cond.sv
module lgx_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0]       res_i,
  input  logic               so_i,
  output lgx_pkg::lgx_crf_t  crf_o
);
  logic zero;

  assign zero      = (res_i == '0);
  assign crf_o.lt  = res_i[W-1];
  assign crf_o.gt  = !res_i[W-1] && !zero;
  assign crf_o.eq  = zero;
  assign crf_o.so  = so_i;
endmodule

// File: rtl/lgx_unit.sv
module lgx_unit #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [3:0]      op_i,
  input  logic            rec_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            so_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic [3:0]      cond_o,
  output logic            cond_we_o
);
  import lgx_pkg::*;

  localparam int CRW = $bits(lgx_crf_t);

  typedef enum logic [1:0] {
    G_REG  = 2'd0,
    G_IMM  = 2'd1,
    G_SEXT = 2'd2
  } grp_e;

  grp_e         grp;
  logic [XLEN-1:0] y_reg;
  logic [XLEN-1:0] y_imm;
  logic [XLEN-1:0] y_sext;
  logic [XLEN-1:0] y_sel;
  lgx_crf_t     crf;
  logic         we_sel;

  always_comb begin
    if (!op_i[3])              grp = G_REG;
    else if (op_i[3:1] == 3'b111) grp = G_SEXT;
    else                       grp = G_IMM;
  end

  lgx_bitwise #(.W(XLEN)) u_bitwise (
    .sel_i (op_i[2:0]),
    .a_i   (a_i),
    .b_i   (b_i),
    .y_o   (y_reg)
  );

  lgx_immed #(.W(XLEN), .IW(IMMW)) u_immed (
    .sel_i (op_i[2:0]),
    .a_i   (a_i),
    .imm_i (imm_i),
    .y_o   (y_imm)
  );

  lgx_sext #(.W(XLEN)) u_sext (
    .half_i (op_i[0]),
    .a_i    (a_i),
    .y_o    (y_sext)
  );

  always_comb begin
    unique case (grp)
      G_REG:   y_sel = y_reg;
      G_IMM:   y_sel = y_imm;
      G_SEXT:  y_sel = y_sext;
      default: y_sel = y_reg;
    endcase
  end

  lgx_cond #(.W(XLEN)) u_cond (
    .res_i (y_sel),
    .so_i  (so_i),
    .crf_o (crf)
  );

  always_comb begin
    unique case (grp)
      G_IMM:   we_sel = (op_i[2:1] == 2'd0);
      default: we_sel = rec_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      cond_we_o <= 1'b0;
      result_o  <= '0;
      cond_o    <= '0;
    end else begin
      valid_o   <= valid_i;
      cond_we_o <= valid_i && we_sel;
      if (valid_i) begin
        result_o <= y_sel;
        cond_o   <= CRW'(crf);
      end
    end
  end
endmodule

// File: rtl/lgx_unit_chk.sv
module lgx_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic [3:0]      op_i,
  input logic            so_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic [3:0]      cond_o,
  input logic            cond_we_o
);
  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);
  assert_we_gated_R9: assert property (@(posedge clk) disable iff (rst)
    cond_we_o |-> valid_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(result_o));
  assert_one_hot_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $countones(cond_o[3:1]) == 1);
  assert_lt_sign_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> cond_o[3] == result_o[XLEN-1]);
  assert_eq_zero_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> cond_o[1] == (result_o == '0));
  assert_so_copy_R5: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> cond_o[0] == $past(so_i));
  assert_andi_writes_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 4'd8 || op_i == 4'd9)) |=> cond_we_o);
  assert_ori_xori_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i >= 4'd10 && op_i <= 4'd13) |=> !cond_we_o);
endmodule

bind lgx_unit lgx_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .so_i      (so_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .cond_o    (cond_o),
  .cond_we_o (cond_we_o)
);

// File: tb/lgx_unit_test.sv
`timescale 1ns/1ps
module lgx_unit_test;
  localparam int XLEN = 32;
  localparam int IMMW = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            valid_i = 1'b0;
  logic [3:0]      op_i = '0;
  logic            rec_i = 1'b0;
  logic [XLEN-1:0] a_i = '0;
  logic [XLEN-1:0] b_i = '0;
  logic [IMMW-1:0] imm_i = '0;
  logic            so_i = 1'b0;
  logic            valid_o;
  logic [XLEN-1:0] result_o;
  logic [3:0]      cond_o;
  logic            cond_we_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  lgx_unit #(.XLEN(XLEN), .IMMW(IMMW)) uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .rec_i(rec_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .so_i(so_i),
    .valid_o(valid_o), .result_o(result_o), .cond_o(cond_o), .cond_we_o(cond_we_o)
  );

  logic [31:0] edge_w [6] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h0000_8000, 32'h7FFF_FFFF, 32'h1234_5678};
  logic [15:0] edge_i [6] = '{16'h0, 16'hFFFF, 16'h8000, 16'h7FFF,
                              16'h0001, 16'hA5C3};

  function automatic logic [31:0] model_res(int op, logic [31:0] a,
                                            logic [31:0] b, logic [15:0] im);
    case (op)
      0:  return a & b;
      1:  return a | b;
      2:  return a ^ b;
      3:  return ~(a & b);
      4:  return ~(a | b);
      5:  return ~(a ^ b);
      6:  return a & ~b;
      7:  return a | ~b;
      8:  return a & {16'h0, im};
      9:  return a & {im, 16'h0};
      10: return a | {16'h0, im};
      11: return a | {im, 16'h0};
      12: return a ^ {16'h0, im};
      13: return a ^ {im, 16'h0};
      14: return {{24{a[7]}}, a[7:0]};
      default: return {{16{a[15]}}, a[15:0]};
    endcase
  endfunction

  function automatic logic [3:0] model_cond(logic [31:0] r, logic so);
    logic lt, gt, eq;
    lt = r[31];
    eq = (r == 32'h0);
    gt = !lt && !eq;
    return {lt, gt, eq, so};
  endfunction

  function automatic logic model_we(int op, logic rec);
    if (op == 8 || op == 9) return 1'b1;
    if (op >= 10 && op <= 13) return 1'b0;
    return rec;
  endfunction

  function automatic string res_tag(int op, logic [31:0] a, logic [31:0] b);
    if (op == 1 && a == b) return "R11";
    if (op <= 2) return "R1";
    if (op <= 7) return "R2";
    if (op <= 13) return "R3";
    return "R4";
  endfunction

  function automatic string we_tag(int op);
    if (op == 8 || op == 9) return "R7";
    if (op >= 10 && op <= 13) return "R8";
    return "R6";
  endfunction

  task automatic fail32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic apply(int op, logic rec, logic [31:0] a, logic [31:0] b,
                       logic [15:0] im, logic so);
    logic [31:0] er;
    logic [3:0]  ec;
    logic        ew;
    logic [31:0] held;
    bit          bad;
    er = model_res(op, a, b, im);
    ec = model_cond(er, so);
    ew = model_we(op, rec);
    bad = 1'b0;
    @(negedge clk);
    valid_i = 1'b1; op_i = 4'(op); rec_i = rec;
    a_i = a; b_i = b; imm_i = im; so_i = so;
    @(negedge clk);
    valid_i = 1'b0;
    vectors++;
    if (valid_o !== 1'b1) begin fail32("R9", "valid", 32'(valid_o), 32'h1); bad = 1'b1; end
    if (result_o !== er) begin fail32(res_tag(op, a, b), "result", result_o, er); bad = 1'b1; end
    if (cond_o !== ec) begin fail32("R5", "cond", 32'(cond_o), 32'(ec)); bad = 1'b1; end
    if (cond_we_o !== ew) begin fail32(we_tag(op), "cond_we", 32'(cond_we_o), 32'(ew)); bad = 1'b1; end
    held = result_o;
    // R9: idle cycle, nothing valid, result held
    @(negedge clk);
    if (valid_o !== 1'b0 || cond_we_o !== 1'b0 || result_o !== held) begin
      fail32("R9", "idle", {30'h0, valid_o, cond_we_o}, 32'h0);
    end
    if (bad) ;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs cleared while reset is held
    vectors++;
    if (valid_o !== 1'b0 || result_o !== '0 || cond_o !== '0 || cond_we_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual %b/%h/%h/%b expected 0/0/0/0",
               valid_o, result_o, cond_o, cond_we_o);
    end
    rst = 1'b0;

    // R11: move register with and without record
    apply(1, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 1'b0);
    apply(1, 1'b0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b1);

    // R1..R8 edge sweep over every opcode and both record settings
    for (int op = 0; op < 16; op++)
      for (int rec = 0; rec < 2; rec++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            apply(op, rec[0], edge_w[i], edge_w[j], edge_i[j], (i + j) % 2 == 1);

    // R4: byte vs halfword sign boundaries
    apply(14, 1'b1, 32'h0000_0080, 32'h0, 16'h0, 1'b0);
    apply(14, 1'b1, 32'hFFFF_FF7F, 32'h0, 16'h0, 1'b0);
    apply(15, 1'b1, 32'h0000_8000, 32'h0, 16'h0, 1'b0);
    apply(15, 1'b1, 32'hFFFF_7FFF, 32'h0, 16'h0, 1'b0);

    // random operands, all opcodes
    for (int k = 0; k < 1500; k++)
      apply(int'($urandom_range(0, 15)), 1'($urandom), $urandom, $urandom,
            16'($urandom), 1'($urandom));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule